// File: doc/BRIEF.md
# Time-Triggered Event Action Scheduler

This block sits inside a timing receiver, after the message decoder. Each decoded timing event gives an absolute execution time, a small event identifier and a reference to a set-value that was loaded earlier. The block does not act when an event arrives. It keeps pending events in a store ordered by time. When the local synchronized clock reaches an event's execution time, the block raises a one-cycle trigger on the output channels that a per-identifier mask selects. In the same cycle it presents the event's identifier and set-value reference, so that downstream logic can apply that value.

Local time is a 64-bit count supplied from outside. It advances by 8 every cycle of the 125 MHz network-recovered clock. Senders expect events to arrive well ahead of their execution time. An event that arrives after its time has passed is reported on a separate late output and is not stored. Nothing is acknowledged back to the sender. The only back-pressure is a ready signal, which drops while the store is full.

Top module: `tev_scheduler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `act_fire`, `act_trig`, `late_pulse`, `late_flag` and `ovf_flag` are 0 and `ev_ready` is 1. Every identifier's channel mask resets to all ones.
- R2: An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. If its execution time T is not late and no earlier-due event is waiting, `act_fire` is high for exactly the one cycle after the first clock edge at which `now_time >= T`.
- R3: Pending events fire in ascending execution time. Events with equal times fire in arrival order. At most one event fires per cycle, and events that are due together fire on consecutive cycles.
- R4: On a firing cycle, `act_trig` equals the channel mask of the fired identifier (bit k drives channel k), and `act_id` and `act_ref` carry that event's identifier and reference. On every other cycle `act_trig` is 0.
- R5: A clock edge with `mask_we` high stores `mask_val` as the mask of identifier `mask_id`. The new mask applies to events that fire after that edge. An identifier whose mask is 0 still pulses `act_fire`, with `act_trig` at 0.
- R6: An accepted event whose time is strictly below `now_time` at the accepting edge is late. It is not stored. `late_pulse` is high for one cycle with `late_id` set to its identifier, and `late_flag` sets. An event whose time equals `now_time` is not late.
- R7: The store holds 16 events. `ev_ready` is low exactly while 16 events are pending. A clock edge with `ev_valid` high and `ev_ready` low discards the event and sets `ovf_flag`.
- R8: `late_flag` and `ovf_flag` are sticky. A clock edge with `clr_flags` high clears a flag unless that flag's set condition occurs on the same edge, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered network clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | 64 | Local synchronized time, advancing 8 per cycle |
| ev_valid | input | 1 | Decoded event present |
| ev_ready | output | 1 | Store can take an event |
| ev_time | input | 64 | Absolute execution time of the event |
| ev_id | input | 4 | Event identifier |
| ev_ref | input | 16 | Set-value reference |
| mask_we | input | 1 | Write strobe for the channel mask table |
| mask_id | input | 4 | Identifier whose mask is written |
| mask_val | input | 4 | New channel mask |
| clr_flags | input | 1 | Clears the sticky status flags |
| act_fire | output | 1 | One-cycle pulse when an event executes |
| act_trig | output | 4 | Trigger pulse per channel |
| act_id | output | 4 | Identifier of the executed event |
| act_ref | output | 16 | Set-value reference of the executed event |
| late_pulse | output | 1 | One-cycle report of a late event |
| late_id | output | 4 | Identifier of the last late event |
| late_flag | output | 1 | Sticky late status |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The hardest case to reach is a full store whose entries include several events with the same execution time, while new events keep arriving. In that state, eviction order, consecutive firing and back-pressure all interact on the same edges. The stimulus first fills all sixteen slots with events for the far future, some of them sharing times, and holds a seventeenth event on the input so that refusal and overflow occur. It then clears the flags while the refused event is still offered, to check that a set on the same edge wins. Finally it lets local time run until the whole backlog drains. A randomized phase follows that mixes late, same-time and future events with mask rewrites.

// File: rtl/tev_pkg.sv
package tev_pkg;
   localparam int TEV_TIME_W   = 64;
   localparam int TEV_ID_W     = 4;
   localparam int TEV_REF_W    = 16;
   localparam int TEV_DEPTH    = 16;
   localparam int TEV_CHANNELS = 4;
   localparam int TEV_TICK     = 8;

   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'd0,
      SLOT_NEW   = 2'd1,
      SLOT_UPPER = 2'd2,
      SLOT_LOWER = 2'd3
   } slot_src_e;
endpackage

// File: rtl/tev_masks.sv
module tev_masks #(
   parameter int ID_W     = 4,
   parameter int CHANNELS = 4,
   parameter bit USE_MASK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ID_W-1:0]     waddr,
   input  logic [CHANNELS-1:0] wdata,
   input  logic [ID_W-1:0]     raddr,
   output logic [CHANNELS-1:0] rdata
);
   localparam int ENTRIES = 1 << ID_W;

   generate
      if (USE_MASK) begin : g_table
         logic [CHANNELS-1:0] tab [ENTRIES];
         for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tab[e] <= '1;
               end else if (we && (waddr == ID_W'(e))) begin
                  tab[e] <= wdata;
               end
            end
         end
         assign rdata = tab[raddr];
      end else begin : g_all
         logic unused_w;
         assign unused_w = &{1'b0, clk, rst_n, we, waddr, wdata, raddr};
         assign rdata    = '1;
      end
   endgenerate
endmodule

// File: rtl/tev_order.sv
module tev_order
   import tev_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int ID_W   = 4,
   parameter int REF_W  = 16,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [TIME_W-1:0] ins_time,
   input  logic [ID_W-1:0]   ins_id,
   input  logic [REF_W-1:0]  ins_ref,
   input  logic              pop_en,
   output logic              head_valid,
   output logic [TIME_W-1:0] head_time,
   output logic [ID_W-1:0]   head_id,
   output logic [REF_W-1:0]  head_ref,
   output logic [CNT_W-1:0]  occ,
   output logic              full
);
   localparam int SLOT_W = TIME_W + ID_W + REF_W;

   logic [SLOT_W-1:0] slot_w [DEPTH];
   logic [DEPTH-1:0]  vld_w;
   logic [DEPTH-1:0]  not_after;
   logic [CNT_W-1:0]  ins_pos;
   logic [SLOT_W-1:0] new_slot;
   logic [CNT_W-1:0]  occ_q;

   assign new_slot = {ins_time, ins_id, ins_ref};

   // Entries are kept sorted, so entries not later than the new one form a prefix.
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign not_after[i] = vld_w[i] && (slot_w[i][SLOT_W-1 -: TIME_W] <= ins_time);
   end

   always_comb begin
      ins_pos = '0;
      for (int k = 0; k < DEPTH; k++) begin
         ins_pos = ins_pos + CNT_W'(not_after[k]);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic              v_q;
      logic [SLOT_W-1:0] d_q;
      logic              up_v;
      logic [SLOT_W-1:0] up_d;
      logic              dn_v;
      logic [SLOT_W-1:0] dn_d;
      slot_src_e         src;

      if (i == DEPTH - 1) begin : g_top
         assign up_v = 1'b0;
         assign up_d = '0;
      end else begin : g_mid
         assign up_v = vld_w[i+1];
         assign up_d = slot_w[i+1];
      end

      if (i == 0) begin : g_bot
         assign dn_v = 1'b0;
         assign dn_d = '0;
      end else begin : g_low
         assign dn_v = vld_w[i-1];
         assign dn_d = slot_w[i-1];
      end

      always_comb begin
         src = SLOT_HOLD;
         if (pop_en && ins_en) begin
            if (CNT_W'(i + 1) < ins_pos)       src = SLOT_UPPER;
            else if (CNT_W'(i + 1) == ins_pos) src = SLOT_NEW;
            else                               src = SLOT_HOLD;
         end else if (pop_en) begin
            src = SLOT_UPPER;
         end else if (ins_en) begin
            if (CNT_W'(i) < ins_pos)       src = SLOT_HOLD;
            else if (CNT_W'(i) == ins_pos) src = SLOT_NEW;
            else                           src = SLOT_LOWER;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            unique case (src)
               SLOT_NEW: begin
                  v_q <= 1'b1;
                  d_q <= new_slot;
               end
               SLOT_UPPER: begin
                  v_q <= up_v;
                  d_q <= up_d;
               end
               SLOT_LOWER: begin
                  v_q <= dn_v;
                  d_q <= dn_d;
               end
               default: begin
                  v_q <= v_q;
                  d_q <= d_q;
               end
            endcase
         end
      end

      assign vld_w[i]  = v_q;
      assign slot_w[i] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else if (ins_en && !pop_en) begin
         occ_q <= occ_q + CNT_W'(1);
      end else if (pop_en && !ins_en) begin
         occ_q <= occ_q - CNT_W'(1);
      end
   end

   assign occ        = occ_q;
   assign full       = (occ_q == CNT_W'(DEPTH));
   assign head_valid = vld_w[0];
   assign head_time  = slot_w[0][SLOT_W-1 -: TIME_W];
   assign head_id    = slot_w[0][REF_W +: ID_W];
   assign head_ref   = slot_w[0][REF_W-1:0];
endmodule

// File: rtl/tev_flags.sv
module tev_flags #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ovf_evt,
   input  logic            late_evt,
   input  logic [ID_W-1:0] late_id_in,
   input  logic            clr,
   output logic            ovf_flag,
   output logic            late_flag,
   output logic            late_pulse,
   output logic [ID_W-1:0] late_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag   <= 1'b0;
         late_flag  <= 1'b0;
         late_pulse <= 1'b0;
         late_id    <= '0;
      end else begin
         if (ovf_evt)  ovf_flag <= 1'b1;
         else if (clr) ovf_flag <= 1'b0;
         if (late_evt) late_flag <= 1'b1;
         else if (clr) late_flag <= 1'b0;
         late_pulse <= late_evt;
         if (late_evt) late_id <= late_id_in;
      end
   end
endmodule

// File: rtl/tev_scheduler.sv
module tev_scheduler
   import tev_pkg::*;
#(
   parameter int TIME_W   = TEV_TIME_W,
   parameter int ID_W     = TEV_ID_W,
   parameter int REF_W    = TEV_REF_W,
   parameter int DEPTH    = TEV_DEPTH,
   parameter int CHANNELS = TEV_CHANNELS,
   parameter bit USE_MASK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TIME_W-1:0]   now_time,
   input  logic                ev_valid,
   output logic                ev_ready,
   input  logic [TIME_W-1:0]   ev_time,
   input  logic [ID_W-1:0]     ev_id,
   input  logic [REF_W-1:0]    ev_ref,
   input  logic                mask_we,
   input  logic [ID_W-1:0]     mask_id,
   input  logic [CHANNELS-1:0] mask_val,
   input  logic                clr_flags,
   output logic                act_fire,
   output logic [CHANNELS-1:0] act_trig,
   output logic [ID_W-1:0]     act_id,
   output logic [REF_W-1:0]    act_ref,
   output logic                late_pulse,
   output logic [ID_W-1:0]     late_id,
   output logic                late_flag,
   output logic                ovf_flag
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tev_scheduler: DEPTH must be at least 2");
      end
      if (ID_W < 1 || ID_W > 8) begin : g_bad_id
         $error("tev_scheduler: ID_W must lie in 1..8");
      end
      if (CHANNELS < 1) begin : g_bad_chan
         $error("tev_scheduler: CHANNELS must be at least 1");
      end
      if (TIME_W < 8) begin : g_bad_time
         $error("tev_scheduler: TIME_W too small");
      end
   endgenerate

   logic              head_valid;
   logic [TIME_W-1:0] head_time;
   logic [ID_W-1:0]   head_id;
   logic [REF_W-1:0]  head_ref;
   logic [CNT_W-1:0]  occ;
   logic              store_full;
   logic              due;
   logic              take;
   logic              is_late;
   logic              store_en;
   logic [CHANNELS-1:0] head_mask;

   assign ev_ready = !store_full;
   assign take     = ev_valid && ev_ready;
   assign is_late  = ev_time < now_time;
   assign store_en = take && !is_late;
   assign due      = head_valid && (now_time >= head_time);

   tev_order #(
      .TIME_W (TIME_W),
      .ID_W   (ID_W),
      .REF_W  (REF_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
   ) u_order (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (store_en),
      .ins_time   (ev_time),
      .ins_id     (ev_id),
      .ins_ref    (ev_ref),
      .pop_en     (due),
      .head_valid (head_valid),
      .head_time  (head_time),
      .head_id    (head_id),
      .head_ref   (head_ref),
      .occ        (occ),
      .full       (store_full)
   );

   tev_masks #(
      .ID_W     (ID_W),
      .CHANNELS (CHANNELS),
      .USE_MASK (USE_MASK)
   ) u_masks (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .waddr (mask_id),
      .wdata (mask_val),
      .raddr (head_id),
      .rdata (head_mask)
   );

   tev_flags #(
      .ID_W (ID_W)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .ovf_evt    (ev_valid && !ev_ready),
      .late_evt   (take && is_late),
      .late_id_in (ev_id),
      .clr        (clr_flags),
      .ovf_flag   (ovf_flag),
      .late_flag  (late_flag),
      .late_pulse (late_pulse),
      .late_id    (late_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_fire <= 1'b0;
         act_trig <= '0;
         act_id   <= '0;
         act_ref  <= '0;
      end else begin
         act_fire <= due;
         act_trig <= due ? head_mask : '0;
         if (due) begin
            act_id  <= head_id;
            act_ref <= head_ref;
         end
      end
   end
endmodule

// File: rtl/tev_scheduler_chk.sv
module tev_scheduler_chk #(
   parameter int CHANNELS = 4,
   parameter int DEPTH    = 16,
   parameter int CNT_W    = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ev_valid,
   input logic                ev_ready,
   input logic                clr_flags,
   input logic                act_fire,
   input logic [CHANNELS-1:0] act_trig,
   input logic                late_pulse,
   input logic                late_flag,
   input logic                ovf_flag,
   input logic [CNT_W-1:0]    occ
);
   AST_TRIG_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_trig != '0) |-> act_fire); // R4

   AST_OVF_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> ovf_flag); // R7

   AST_LATE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      late_pulse |-> late_flag); // R6

   AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (late_flag && !clr_flags) |=> late_flag); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_flags) |=> ovf_flag); // R8

   AST_FIRE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> ($past(occ) != '0)); // R3

   AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH)); // R7
endmodule

bind tev_scheduler tev_scheduler_chk #(
   .CHANNELS (CHANNELS),
   .DEPTH    (DEPTH),
   .CNT_W    (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid   (ev_valid),
   .ev_ready   (ev_ready),
   .clr_flags  (clr_flags),
   .act_fire   (act_fire),
   .act_trig   (act_trig),
   .late_pulse (late_pulse),
   .late_flag  (late_flag),
   .ovf_flag   (ovf_flag),
   .occ        (occ)
);

// File: tb/tev_scheduler_test.sv
`timescale 1ns/1ps
module tev_scheduler_test;
   localparam int TW = 64;
   localparam int IW = 4;
   localparam int RW = 16;
   localparam int DP = 16;
   localparam int CH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] now_t = 64'd4096;
   logic          ev_valid = 1'b0;
   logic          ev_ready;
   logic [TW-1:0] ev_time = '0;
   logic [IW-1:0] ev_id = '0;
   logic [RW-1:0] ev_ref = '0;
   logic          mask_we = 1'b0;
   logic [IW-1:0] mask_id = '0;
   logic [CH-1:0] mask_val = '0;
   logic          clr_flags = 1'b0;
   logic          act_fire;
   logic [CH-1:0] act_trig;
   logic [IW-1:0] act_id;
   logic [RW-1:0] act_ref;
   logic          late_pulse;
   logic [IW-1:0] late_id;
   logic          late_flag;
   logic          ovf_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) now_t <= now_t + 64'd8;

   tev_scheduler uut (
      .clk(clk), .rst_n(rst_n), .now_time(now_t),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_time(ev_time),
      .ev_id(ev_id), .ev_ref(ev_ref),
      .mask_we(mask_we), .mask_id(mask_id), .mask_val(mask_val),
      .clr_flags(clr_flags),
      .act_fire(act_fire), .act_trig(act_trig), .act_id(act_id), .act_ref(act_ref),
      .late_pulse(late_pulse), .late_id(late_id),
      .late_flag(late_flag), .ovf_flag(ovf_flag)
   );

   // Behavioural reference: arrival-ordered list, earliest searched on each edge.
   typedef struct { logic [TW-1:0] t; logic [IW-1:0] id; logic [RW-1:0] rf; } ev_s;
   ev_s           pend[$];
   logic [CH-1:0] m_mask [16];
   logic          x_fire = 0, x_lpulse = 0, x_lflag = 0, x_oflag = 0;
   logic [CH-1:0] x_trig = 0;
   logic [IW-1:0] x_id = 0, x_lid = 0;
   logic [RW-1:0] x_ref = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         pend.delete();
         for (int k = 0; k < 16; k++) m_mask[k] = '1;
         x_fire = 0; x_trig = 0; x_lpulse = 0; x_lflag = 0; x_oflag = 0;
      end else begin
         bit rdy;
         bit acc;
         bit lt;
         rdy = (pend.size() < DP);
         x_fire = 0; x_trig = 0;
         if (pend.size() > 0) begin
            int b;
            b = 0;
            for (int k = 1; k < pend.size(); k++)
               if (pend[k].t < pend[b].t) b = k;
            if (now_t >= pend[b].t) begin
               x_fire = 1; x_trig = m_mask[pend[b].id];
               x_id = pend[b].id; x_ref = pend[b].rf;
               pend.delete(b);
            end
         end
         acc = ev_valid && rdy;
         lt  = acc && (ev_time < now_t);
         x_lpulse = lt;
         if (lt) x_lid = ev_id;
         if (ev_valid && !rdy) x_oflag = 1; else if (clr_flags) x_oflag = 0;
         if (lt) x_lflag = 1; else if (clr_flags) x_lflag = 0;
         if (acc && !lt) pend.push_back('{ev_time, ev_id, ev_ref});
         if (mask_we) m_mask[mask_id] = mask_val;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R3", "act_fire", 64'(act_fire), 64'(x_fire));
         chk("R4", "act_trig", 64'(act_trig), 64'(x_trig));
         if (x_fire) begin
            chk("R4", "act_id", 64'(act_id), 64'(x_id));
            chk("R4", "act_ref", 64'(act_ref), 64'(x_ref));
         end
         chk("R7", "ev_ready", 64'(ev_ready), 64'(pend.size() < DP));
         chk("R7", "ovf_flag", 64'(ovf_flag), 64'(x_oflag));
         chk("R6", "late_pulse", 64'(late_pulse), 64'(x_lpulse));
         chk("R8", "late_flag", 64'(late_flag), 64'(x_lflag));
         if (x_lpulse) chk("R6", "late_id", 64'(late_id), 64'(x_lid));
      end
   end

   task automatic send(input logic [TW-1:0] t, input logic [IW-1:0] id, input logic [RW-1:0] rf);
      ev_valid = 1; ev_time = t; ev_id = id; ev_ref = rf;
      @(negedge clk);
      ev_valid = 0;
   endtask

   task automatic set_mask(input logic [IW-1:0] id, input logic [CH-1:0] m);
      mask_we = 1; mask_id = id; mask_val = m;
      @(negedge clk);
      mask_we = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      logic [TW-1:0] t0;
      @(negedge clk); @(negedge clk);
      // R1: outputs idle during reset
      chk("R1", "ready in reset", 64'(ev_ready), 64'd1);
      chk("R1", "fire in reset", 64'(act_fire), 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "flags after reset", 64'({late_flag, ovf_flag}), 64'd0);
      // R1: default mask is all ones
      send(now_t + 64'd16, 4'd9, 16'h0909);
      idle(4);

      // R5: program masks
      set_mask(4'd1, 4'b0001);
      set_mask(4'd2, 4'b0110);
      set_mask(4'd3, 4'b1000);
      set_mask(4'd5, 4'b0000);

      // R2: single event
      send(now_t + 64'd80, 4'd1, 16'h1111);
      idle(16);

      // R3: out-of-order arrivals
      t0 = now_t;
      send(t0 + 64'd200, 4'd2, 16'h2002);
      send(t0 + 64'd100, 4'd3, 16'h3003);
      send(t0 + 64'd150, 4'd1, 16'h1001);
      idle(35);

      // R3: equal execution times fire in arrival order
      t0 = now_t + 64'd120;
      send(t0, 4'd3, 16'hA001);
      send(t0, 4'd1, 16'hA002);
      send(t0, 4'd2, 16'hA003);
      idle(25);

      // R6: time equal to now is not late
      send(now_t, 4'd4, 16'h4444);
      idle(3);
      // R6: late events
      send(now_t - 64'd8, 4'd6, 16'h6666);
      send(now_t - 64'd1000, 4'd7, 16'h7777);
      idle(3);
      clr_flags = 1; @(negedge clk); clr_flags = 0;
      idle(2);

      // R5: zero mask still fires
      send(now_t + 64'd40, 4'd5, 16'h5555);
      idle(10);

      // R7 / R8: fill store, refuse, clear while refusing
      t0 = now_t + 64'd1600;
      for (int k = 0; k < DP; k++)
         send(t0 + 64'((k % 5) * 8), 4'(k), 16'(16'hB000 + k));
      ev_valid = 1; ev_time = t0; ev_id = 4'd2; ev_ref = 16'hBEEF;
      idle(3);
      clr_flags = 1; @(negedge clk); clr_flags = 0;
      ev_valid = 0;
      idle(2);
      clr_flags = 1; @(negedge clk); clr_flags = 0;
      set_mask(4'd0, 4'b1010);
      idle(240);

      // Randomized mix
      for (int it = 0; it < 400; it++) begin
         ev_valid = ($urandom_range(0, 1) == 1);
         ev_time  = now_t + 64'($urandom_range(0, 900)) - 64'd48;
         ev_id    = 4'($urandom_range(0, 15));
         ev_ref   = 16'($urandom);
         mask_we  = ($urandom_range(0, 15) == 0);
         mask_id  = 4'($urandom_range(0, 15));
         mask_val = 4'($urandom);
         clr_flags = ($urandom_range(0, 31) == 0);
         @(negedge clk);
      end
      ev_valid = 0; mask_we = 0; clr_flags = 0;
      idle(200);
      finish_up();
   end
endmodule